// File: doc/BRIEF.md
# Barrel Shifter with Carry Out

This block moves a data word by a variable number of places in a single combinational pass. It supports five shift kinds: logical left, logical right, arithmetic right, rotate right, and a one-place rotate that passes through the carry flag. Besides the shifted word it returns a carry-out bit, which is the last bit that left the word. An arithmetic or logic stage downstream consumes the result, and a flag register downstream stores the carry-out.

The shift count comes from one of two places, picked by a select input. One is a short immediate field that is wide enough to count up to one less than the word width. The other is the low byte of a register operand. A register count can be much larger than the word width, so the block defines a result and a carry for every count from 0 to 255. The block has no clock and no state: each output follows its inputs through combinational logic only.

Top module: `barrel_shift_unit`

## Requirements
- R1: Kind code 0 is a logical left shift. Vacated low bits become 0. For a count n from 1 to 32, `cout` is input bit 32−n.
- R2: Kind code 1 is a logical right shift. Vacated high bits become 0. For a count n from 1 to 32, `cout` is input bit n−1.
- R3: Kind code 2 is an arithmetic right shift. Vacated high bits copy input bit 31. For any count of 32 or more, every result bit and `cout` equal input bit 31.
- R4: Kind code 3 is a rotate right by the count modulo 32, and `cout` equals result bit 31. A nonzero count whose remainder is 0 leaves the word unchanged and sets `cout` to input bit 31.
- R5: Kind code 4 ignores the count and moves the word right by exactly one place. `cin` enters bit 31 and input bit 0 becomes `cout`.
- R6: For either logical shift, a count of exactly 32 gives an all-zero word; `cout` is input bit 0 for a left shift and input bit 31 for a right shift. A count above 32 gives an all-zero word and `cout` = 0.
- R7: For kind codes 0 to 3, a count of 0 passes `din` to `dout` unchanged, and `cout` equals `cin`.
- R8: When `amt_sel` = 0, the count is `amt_imm`, zero-extended, and `amt_reg` has no effect. When `amt_sel` = 1, the count is `amt_reg`, and `amt_imm` has no effect.
- R9: Kind codes 5, 6 and 7 pass `din` to `dout` unchanged, and `cout` equals `cin`.
- R10: A left shift by 4 of a 4-bit value, followed by an OR with a second 4-bit value, packs the two nibbles into one byte: the first value is the high nibble and the second is the low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | 32 | Word to be shifted |
| kind | input | 3 | Shift kind code (0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry) |
| amt_imm | input | 5 | Immediate shift count |
| amt_reg | input | 8 | Register shift count (low byte of the register operand) |
| amt_sel | input | 1 | Count source: 0 immediate, 1 register |
| cin | input | 1 | Current carry flag |
| dout | output | 32 | Shifted word |
| cout | output | 1 | Carry-out: the last bit shifted out |

## Verification
The bench builds the block with its default parameters: a 32-bit word and an 8-bit register count. With an 8-bit count, the register path reaches every count up to 255. That range covers the exact-width boundary at 32, the counts just past it, counts that are multiples of 32 for the rotate, and the saturated arithmetic case. The 5-bit immediate path covers every in-range count. The bench also sends disagreeing values on the unselected count source, so that any leak from that source would show up in the result.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shf_kind_e;

endpackage

// File: rtl/shf_amount_sel.sv
module shf_amount_sel #(
    parameter int IMM_W = 5,
    parameter int AMT_W = 8
) (
    input  logic [IMM_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] reg_amt,
    input  logic             use_reg,
    output logic [AMT_W-1:0] count
);

    localparam int PAD_W = AMT_W - IMM_W;

    logic [AMT_W-1:0] imm_wide;

    assign imm_wide = {{PAD_W{1'b0}}, imm_amt};

    always_comb begin
        if (use_reg) begin
            count = reg_amt;
        end else begin
            count = imm_wide;
        end
    end

endmodule

// File: rtl/shf_right_engine.sv
module shf_right_engine #(
    parameter int W = 32
) (
    input  logic [W-1:0]         word,
    input  logic [$clog2(W)-1:0] amt_lo,
    input  logic                 fill,
    input  logic                 rotate,
    input  logic                 saturate,
    output logic [W-1:0]         result
);

    localparam int L = $clog2(W);

    logic [L:0][W-1:0] stg;

    assign stg[0] = word;

    generate
        for (genvar i = 0; i < L; i++) begin : g_stage
            localparam int S = 1 << i;
            logic [W-1:0] moved;
            assign moved = rotate ? {stg[i][S-1:0], stg[i][W-1:S]}
                                  : {{S{fill}}, stg[i][W-1:S]};
            assign stg[i+1] = amt_lo[i] ? moved : stg[i];
        end
    endgenerate

    always_comb begin
        if (saturate) begin
            result = {W{fill}};
        end else begin
            result = stg[L];
        end
    end

endmodule

// File: rtl/shf_carry_pick.sv
module shf_carry_pick
    import shf_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     word,
    input  logic [2:0]       kind,
    input  logic [AMT_W-1:0] count,
    input  logic             cin,
    output logic             cout
);

    localparam int L = $clog2(W);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

    logic [L-1:0] low_cnt;
    logic [L-1:0] left_idx;
    logic [L-1:0] right_idx;
    logic         in_range;
    logic         is_zero;

    assign low_cnt   = count[L-1:0];
    assign left_idx  = L'(0) - low_cnt;
    assign right_idx = low_cnt - L'(1);
    assign in_range  = (count <= W_AMT);
    assign is_zero   = (count == '0);

    always_comb begin
        cout = cin;
        case (kind)
            SK_RRX: cout = word[0];
            SK_LSL: begin
                if (!is_zero) cout = in_range ? word[left_idx] : 1'b0;
            end
            SK_LSR: begin
                if (!is_zero) cout = in_range ? word[right_idx] : 1'b0;
            end
            SK_ASR: begin
                if (!is_zero) cout = in_range ? word[right_idx] : word[W-1];
            end
            SK_ROR: begin
                if (!is_zero) cout = (low_cnt == '0) ? word[W-1] : word[right_idx];
            end
            default: cout = cin;
        endcase
    end

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
    import shf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [WIDTH-1:0]         din,
    input  logic [2:0]               kind,
    input  logic [$clog2(WIDTH)-1:0] amt_imm,
    input  logic [AMT_W-1:0]         amt_reg,
    input  logic                     amt_sel,
    input  logic                     cin,
    output logic [WIDTH-1:0]         dout,
    output logic                     cout
);

    localparam int L = $clog2(WIDTH);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);

    shf_kind_e        k;
    logic [AMT_W-1:0] count;
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] eng_in;
    logic [WIDTH-1:0] eng_out;
    logic [WIDTH-1:0] rev_out;
    logic             is_left;
    logic             fill;
    logic             rotate;
    logic             saturate;

    assign k = shf_kind_e'(kind);

    shf_amount_sel #(.IMM_W(L), .AMT_W(AMT_W)) u_amt (
        .imm_amt (amt_imm),
        .reg_amt (amt_reg),
        .use_reg (amt_sel),
        .count   (count)
    );

    generate
        for (genvar j = 0; j < WIDTH; j++) begin : g_rev
            assign rev_in[j]  = din[WIDTH-1-j];
            assign rev_out[j] = eng_out[WIDTH-1-j];
        end
    endgenerate

    assign is_left  = (k == SK_LSL);
    assign fill     = (k == SK_ASR) & din[WIDTH-1];
    assign rotate   = (k == SK_ROR);
    assign saturate = (count >= W_AMT) & ~rotate;
    assign eng_in   = is_left ? rev_in : din;

    shf_right_engine #(.W(WIDTH)) u_eng (
        .word     (eng_in),
        .amt_lo   (count[L-1:0]),
        .fill     (fill),
        .rotate   (rotate),
        .saturate (saturate),
        .result   (eng_out)
    );

    shf_carry_pick #(.W(WIDTH), .AMT_W(AMT_W)) u_cy (
        .word  (din),
        .kind  (kind),
        .count (count),
        .cin   (cin),
        .cout  (cout)
    );

    always_comb begin
        case (k)
            SK_RRX: dout = {cin, din[WIDTH-1:1]};
            SK_LSL: dout = (count == '0) ? din : rev_out;
            SK_LSR, SK_ASR, SK_ROR: dout = (count == '0) ? din : eng_out;
            default: dout = din;
        endcase
    end

    always_comb begin
        if (k == SK_ROR) begin
            AST_ROTATE_KEEPS_ONES: assert ($countones(dout) == $countones(din)); // R4
        end
        if ((k == SK_LSL || k == SK_LSR) && count > W_AMT) begin
            AST_LOGIC_PAST_WIDTH: assert (dout == '0 && !cout); // R6
        end
        if (k == SK_ASR && count >= W_AMT) begin
            AST_ASR_SIGN_FLOOD: assert ((dout == '0 || dout == '1) && cout == din[WIDTH-1]); // R3
        end
        if ((k == SK_LSL || k == SK_LSR) && count != '0) begin
            AST_NO_NEW_ONES: assert ($countones(dout) + int'(cout) <= $countones(din)); // R1
        end
        if (k == SK_RRX) begin
            AST_RRX_THROUGH_CARRY: assert (cout == din[0] && dout[WIDTH-1] == cin); // R5
        end
    end

endmodule

// File: tb/sim_barrel_shift_unit.sv
module sim_barrel_shift_unit;

    typedef struct {
        logic [31:0] exp_d;
        logic        exp_c;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic [31:0] din = '0;
    logic [2:0]  kind = '0;
    logic [4:0]  amt_imm = '0;
    logic [7:0]  amt_reg = '0;
    logic        amt_sel = 1'b0;
    logic        cin = 1'b0;
    logic [31:0] dout;
    logic        cout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t q[$];

    always #2 clk = ~clk;

    barrel_shift_unit u0 (
        .din(din), .kind(kind), .amt_imm(amt_imm), .amt_reg(amt_reg),
        .amt_sel(amt_sel), .cin(cin), .dout(dout), .cout(cout)
    );

    function automatic void ref_model(input logic [31:0] d, input logic [2:0] kd,
                                      input logic [7:0] n, input logic c,
                                      output logic [31:0] r, output logic rc);
        logic [63:0] t;
        int m;
        r = d; rc = c;
        if (kd == 3'd4) begin
            r = {c, d[31:1]}; rc = d[0];
        end else if (kd <= 3'd3 && n != 0) begin
            case (kd)
                3'd0: begin t = {32'h0, d} << n; r = t[31:0]; rc = t[32]; end
                3'd1: begin t = {d, 32'h0} >> n; r = t[63:32]; rc = t[31]; end
                3'd2: begin t = $unsigned($signed({d, 32'h0}) >>> n); r = t[63:32]; rc = t[31]; end
                default: begin
                    m = int'(n) % 32;
                    r = (m == 0) ? d : ((d >> m) | (d << (32 - m)));
                    rc = r[31];
                end
            endcase
        end
    endfunction

    function automatic string tag_for(input logic [2:0] kd, input logic [7:0] n);
        if (kd >= 3'd5) return "R9";
        if (kd == 3'd4) return "R5";
        if (n == 0) return "R7";
        if (kd <= 3'd1 && n >= 32) return "R6";
        case (kd)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic drive(input logic [2:0] kd, input logic [7:0] n, input logic sel,
                         input logic [31:0] d, input logic c, input string tag);
        item_t it;
        @(posedge clk);
        din <= d; kind <= kd; cin <= c; amt_sel <= sel;
        if (sel) begin
            amt_reg <= n; amt_imm <= 5'($urandom());
        end else begin
            amt_imm <= n[4:0]; amt_reg <= 8'($urandom()) | 8'h20;
        end
        ref_model(d, kd, sel ? n : {3'b0, n[4:0]}, c, it.exp_d, it.exp_c);
        it.tag = tag;
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (dout !== it.exp_d || cout !== it.exp_c) begin
                errors++;
                $display("FAIL %s dout=%h exp=%h cout=%b exp=%b", it.tag, dout, it.exp_d, cout, it.exp_c);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        // R7 and R9: passthrough with zero count or unused kind codes
        drive(3'd0, 8'd0, 1'b0, 32'hDEADBEEF, 1'b1, "R7");
        drive(3'd6, 8'd9, 1'b1, 32'h12345678, 1'b1, "R9");
        drive(3'd7, 8'd3, 1'b0, 32'h87654321, 1'b0, "R9");
        drive(3'd5, 8'd40, 1'b1, 32'hA5A5A5A5, 1'b1, "R9");
        // R6: boundary at the word width
        drive(3'd1, 8'd32, 1'b1, 32'h80000000, 1'b0, "R6");
        drive(3'd0, 8'd32, 1'b1, 32'h00000001, 1'b0, "R6");
        drive(3'd1, 8'd33, 1'b1, 32'hFFFFFFFF, 1'b1, "R6");
        // R3: saturated arithmetic shift
        drive(3'd2, 8'd200, 1'b1, 32'h80000001, 1'b0, "R3");
        drive(3'd2, 8'd31, 1'b0, 32'h7FFFFFFF, 1'b1, "R3");
        // R4: rotate by a multiple of the width
        drive(3'd3, 8'd64, 1'b1, 32'h80000002, 1'b0, "R4");
        drive(3'd3, 8'd32, 1'b1, 32'h00000003, 1'b1, "R4");
        // R5: count must be ignored
        drive(3'd4, 8'd17, 1'b1, 32'h00000001, 1'b1, "R5");
        drive(3'd4, 8'd0, 1'b0, 32'hFFFFFFFE, 1'b0, "R5");
        // R10: nibble packing
        drive(3'd0, 8'd4, 1'b0, 32'h0000000B, 1'b0, "R10");
        @(negedge clk);
        checks++;
        if ((dout | 32'h6) !== 32'hB6) begin
            errors++;
            $display("FAIL R10 packed=%h exp=%h", dout | 32'h6, 32'hB6);
        end
        // R8: both count sources, other source carries noise
        for (int kd = 0; kd < 5; kd++) begin
            for (int n = 0; n < 32; n++) begin
                drive(3'(kd), 8'(n), 1'b0, $urandom(), 1'($urandom()), "R8");
            end
        end
        // sweep of all kinds over register counts
        for (int kd = 0; kd < 8; kd++) begin
            for (int n = 0; n < 256; n += ((n < 40) ? 1 : 23)) begin
                drive(3'(kd), 8'(n), 1'b1, $urandom(), 1'($urandom()), tag_for(3'(kd), 8'(n)));
            end
        end
        drive(3'd2, 8'd255, 1'b1, 32'h40000000, 1'b1, "R3");
        drive(3'd1, 8'd255, 1'b1, 32'hFFFFFFFF, 1'b1, "R6");
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        finish_run();
    end

endmodule